// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a twisted-pair segment has a live partner on the far end. While the local side is not sending data, it emits a short link pulse on a fixed cadence. It also watches the receive side for frames and for correctly oriented link pulses. If the receive side stays silent for too long, the block declares the link failed. In that state it withholds the transmit, receive and loopback enables, but it keeps sending its own link pulses.

The link is qualified again by either of two events: one received frame, or two accepted pulses spaced inside an upper window. A pulse that follows the previously accepted one too closely is treated as noise and dropped. A pulse of the wrong polarity is dropped as well. Once qualified, the block only restores the enables after transmit and receive activity have both gone quiet. A test-enable input switches the whole function off: the link then reads as up and no pulses are sent.

All intervals are counted in ticks of a millisecond strobe `msTick`, and each interval is a parameter. The pulse strobe width is a parameter counted in clock cycles.

Top module: `link_integrity`

## Requirements
- R1: After reset with test enabled, `linkFail` is 1, `txEnable`, `rxEnable` and `loopEnable` are 0, and `linkPulse` is 0.
- R2: While no data is being sent, a rising edge of `linkPulse` occurs every TX_PERIOD ticks (default 16), and each pulse is high for STROBE_CYC clock cycles (default 13).
- R3: While the link is up and `txActive` is 1, no new pulse starts. After `txActive` falls, the first pulse starts on the TX_PERIOD-th following tick, so a silent interval comes first.
- R4: With the link up, after LOSS_TIME ticks (default 95) with no received frame and no accepted pulse, `linkFail` rises. A frame or an accepted pulse restarts this count.
- R5: While `linkFail` is 1, all three enables are 0, and link pulses are still emitted even when `txActive` is 1.
- R6: In link fail, `rxFrame` at 1 qualifies the link. The enables return only after `txActive` and `rxFrame` are both 0.
- R7: In link fail, two accepted pulses spaced g ticks apart, with MIN_GAP ≤ g ≤ MAX_GAP (defaults 4 and 70), qualify the link. A spacing of MAX_GAP+1 or more does not.
- R8: A good-polarity pulse that arrives fewer than MIN_GAP ticks after the last accepted pulse is discarded. It neither qualifies the link nor restarts the spacing window.
- R9: A pulse with `pulsePolOk` at 0 is ignored. It neither counts toward qualification nor restarts the loss count.
- R10: With `testEnable` at 0, `linkFail` is 0 in the same cycle, all enables are 1, no pulses are emitted, and no silence interval causes link fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle strobe per timing unit (nominally 1 ms) |
| testEnable | input | 1 | 1 enables link integrity testing |
| txActive | input | 1 | Local side is sending data |
| rxFrame | input | 1 | A frame is being received |
| pulseSeen | input | 1 | One-cycle strobe: a link pulse was detected |
| pulsePolOk | input | 1 | Polarity of the detected pulse is correct (1) or reversed (0) |
| linkPulse | output | 1 | Link pulse transmit strobe |
| linkFail | output | 1 | Link failed |
| txEnable | output | 1 | Transmit path allowed |
| rxEnable | output | 1 | Receive path allowed |
| loopEnable | output | 1 | Loopback path allowed |

## Verification
A link pulse becomes visible one clock edge after the tick that completes its interval. The bench therefore counts pulse rising edges in a monitor that samples two nanoseconds after each rising edge. It compares those counts only after whole tick groups have elapsed. A qualifying pulse or frame moves the state at the next edge, and the idle condition takes one more edge. Link loss is registered on the tick that reaches LOSS_TIME and reaches `linkFail` one edge later. For that reason every state check waits at least two falling edges after its stimulus. The disable path is combinational, so it is checked one nanosecond after the input changes.

// File: rtl/linkmon_pkg.sv
package linkmon_pkg;

  typedef enum logic [1:0] {
    LS_FAIL  = 2'd0,
    LS_ARMED = 2'd1,
    LS_UP    = 2'd2
  } link_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic lossClear;
    logic silenceRestart;
  } ctrl_strobes_t;

  // datapath -> control flags
  typedef struct packed {
    logic lossExpired;
    logic pairOk;
  } dp_flags_t;

endpackage

// File: rtl/linkmon_dpath.sv
module linkmon_dpath
  import linkmon_pkg::*;
#(
  parameter int TX_PERIOD  = 16,
  parameter int LOSS_TIME  = 95,
  parameter int MIN_GAP    = 4,
  parameter int MAX_GAP    = 70,
  parameter int STROBE_CYC = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          msTick,
  input  logic          rxFrame,
  input  logic          pulseSeen,
  input  logic          pulsePolOk,
  input  ctrl_strobes_t strobes,
  output dp_flags_t     flags,
  output logic          linkPulse
);

  localparam int SIL_W  = $clog2(TX_PERIOD + 1);
  localparam int LOSS_W = $clog2(LOSS_TIME + 1);
  localparam int GAP_W  = $clog2(MAX_GAP + 2);
  localparam int STB_W  = $clog2(STROBE_CYC + 1);

  localparam logic [SIL_W-1:0]  SIL_LAST = SIL_W'(TX_PERIOD - 1);
  localparam logic [LOSS_W-1:0] LOSS_V   = LOSS_W'(LOSS_TIME);
  localparam logic [GAP_W-1:0]  GAP_SAT  = GAP_W'(MAX_GAP + 1);
  localparam logic [GAP_W-1:0]  GAP_MIN  = GAP_W'(MIN_GAP);
  localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(MAX_GAP);
  localparam logic [STB_W-1:0]  STB_LOAD = STB_W'(STROBE_CYC);

  // ---------------- idle pulse generator ----------------
  logic [SIL_W-1:0] silCnt;
  logic [STB_W-1:0] stbCnt;
  logic             fireNow;

  assign fireNow = !strobes.silenceRestart && msTick && (silCnt == SIL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      silCnt <= '0;
    end else if (strobes.silenceRestart) begin
      silCnt <= '0;
    end else if (msTick) begin
      silCnt <= (silCnt == SIL_LAST) ? '0 : silCnt + SIL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbCnt <= '0;
    end else if (fireNow) begin
      stbCnt <= STB_LOAD;
    end else if (stbCnt != '0) begin
      stbCnt <= stbCnt - STB_W'(1);
    end
  end

  assign linkPulse = (stbCnt != '0);

  // ---------------- receive pulse qualification ----------------
  logic [GAP_W-1:0]  gapCnt;
  logic [LOSS_W-1:0] lossCnt;
  logic              goodPulse;
  logic              tooSoon;
  logic              accepted;

  assign goodPulse = pulseSeen && pulsePolOk;
  assign tooSoon   = (gapCnt < GAP_MIN);
  assign accepted  = goodPulse && !tooSoon;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= GAP_SAT;
    end else if (accepted) begin
      gapCnt <= '0;
    end else if (msTick && (gapCnt != GAP_SAT)) begin
      gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossCnt <= '0;
    end else if (strobes.lossClear || rxFrame || accepted) begin
      lossCnt <= '0;
    end else if (msTick && (lossCnt != LOSS_V)) begin
      lossCnt <= lossCnt + LOSS_W'(1);
    end
  end

  assign flags.pairOk      = accepted && (gapCnt <= GAP_MAX);
  assign flags.lossExpired = (lossCnt == LOSS_V);

  // ---------------- assertions ----------------
  a_r2_fire_raises_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fireNow |=> linkPulse);

  a_r3_restart_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    strobes.silenceRestart |=> !$rose(linkPulse));

  a_r8_noise_keeps_window: assert property (@(posedge clk) disable iff (!rstN)
    (goodPulse && tooSoon && !msTick) |=> (gapCnt == $past(gapCnt)));

  a_r9_badpol_keeps_loss: assert property (@(posedge clk) disable iff (!rstN)
    (pulseSeen && !pulsePolOk && !rxFrame && !strobes.lossClear && !msTick)
      |=> (lossCnt == $past(lossCnt)));

  a_r4_loss_bounded: assert property (@(posedge clk) disable iff (!rstN)
    lossCnt <= LOSS_V);

endmodule

// File: rtl/linkmon_ctrl.sv
module linkmon_ctrl
  import linkmon_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          testEnable,
  input  logic          txActive,
  input  logic          rxFrame,
  input  dp_flags_t     flags,
  output ctrl_strobes_t strobes,
  output logic          linkFail
);

  link_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (!testEnable) begin
      stateNext = LS_UP;
    end else begin
      unique case (state)
        LS_FAIL:  if (rxFrame || flags.pairOk)  stateNext = LS_ARMED;
        LS_ARMED: if (!txActive && !rxFrame)    stateNext = LS_UP;
        LS_UP:    if (flags.lossExpired)        stateNext = LS_FAIL;
        default:                                stateNext = LS_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LS_FAIL;
    else       state <= stateNext;
  end

  assign strobes.lossClear      = (state != LS_UP);
  assign strobes.silenceRestart = !testEnable || (txActive && (state == LS_UP));
  assign linkFail               = testEnable && (state != LS_UP);

  // ---------------- assertions ----------------
  a_r4_loss_to_fail: assert property (@(posedge clk) disable iff (!rstN)
    (testEnable && state == LS_UP && flags.lossExpired) |=> (state == LS_FAIL));

  a_r6_armed_waits_idle: assert property (@(posedge clk) disable iff (!rstN)
    (testEnable && state == LS_ARMED && (txActive || rxFrame)) |=> (state == LS_ARMED));

  a_r7_fail_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    (testEnable && state == LS_FAIL && !rxFrame && !flags.pairOk) |=> (state == LS_FAIL));

  a_r10_disable_forces_up: assert property (@(posedge clk) disable iff (!rstN)
    !testEnable |=> (state == LS_UP));

endmodule

// File: rtl/link_integrity.sv
module link_integrity
  import linkmon_pkg::*;
#(
  parameter int TX_PERIOD  = 16,
  parameter int LOSS_TIME  = 95,
  parameter int MIN_GAP    = 4,
  parameter int MAX_GAP    = 70,
  parameter int STROBE_CYC = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic testEnable,
  input  logic txActive,
  input  logic rxFrame,
  input  logic pulseSeen,
  input  logic pulsePolOk,
  output logic linkPulse,
  output logic linkFail,
  output logic txEnable,
  output logic rxEnable,
  output logic loopEnable
);

  ctrl_strobes_t strobes;
  dp_flags_t     flags;

  linkmon_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .testEnable (testEnable),
    .txActive   (txActive),
    .rxFrame    (rxFrame),
    .flags      (flags),
    .strobes    (strobes),
    .linkFail   (linkFail)
  );

  linkmon_dpath #(
    .TX_PERIOD  (TX_PERIOD),
    .LOSS_TIME  (LOSS_TIME),
    .MIN_GAP    (MIN_GAP),
    .MAX_GAP    (MAX_GAP),
    .STROBE_CYC (STROBE_CYC)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .rxFrame    (rxFrame),
    .pulseSeen  (pulseSeen),
    .pulsePolOk (pulsePolOk),
    .strobes    (strobes),
    .flags      (flags),
    .linkPulse  (linkPulse)
  );

  assign txEnable   = !linkFail;
  assign rxEnable   = !linkFail;
  assign loopEnable = !linkFail;

  a_r5_enables_off_in_fail: assert property (@(posedge clk) disable iff (!rstN)
    linkFail |-> (!txEnable && !rxEnable && !loopEnable));

endmodule

// File: tb/sim_link_integrity.sv
`timescale 1ns/1ps
module sim_link_integrity;

  localparam int TX_PERIOD  = 16;
  localparam int LOSS_TIME  = 95;
  localparam int MIN_GAP    = 4;
  localparam int MAX_GAP    = 70;
  localparam int STROBE_CYC = 13;
  localparam int TICK_CYC   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, testEnable = 1'b1, txActive = 1'b0, rxFrame = 1'b0;
  logic pulseSeen = 1'b0, pulsePolOk = 1'b1;
  logic linkPulse, linkFail, txEnable, rxEnable, loopEnable;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_integrity #(
    .TX_PERIOD(TX_PERIOD), .LOSS_TIME(LOSS_TIME), .MIN_GAP(MIN_GAP),
    .MAX_GAP(MAX_GAP), .STROBE_CYC(STROBE_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .msTick(msTick), .testEnable(testEnable),
    .txActive(txActive), .rxFrame(rxFrame), .pulseSeen(pulseSeen),
    .pulsePolOk(pulsePolOk), .linkPulse(linkPulse), .linkFail(linkFail),
    .txEnable(txEnable), .rxEnable(rxEnable), .loopEnable(loopEnable)
  );

  // monitor: samples 2 ns after each rising edge
  int cycleNo = 0, riseCount = 0, lastRise = -1, lastPeriod = 0;
  int highRun = 0, lastWidth = 0;
  logic prevPulse = 1'b0;
  always @(posedge clk) begin
    #2;
    cycleNo++;
    if (linkPulse && !prevPulse) begin
      if (lastRise >= 0) lastPeriod = cycleNo - lastRise;
      lastRise = cycleNo;
      riseCount++;
    end
    if (linkPulse) highRun++;
    else if (prevPulse) begin lastWidth = highRun; highRun = 0; end
    prevPulse = linkPulse;
  end

  typedef struct packed {
    logic [7:0] gap;
    logic       polOk;
    logic       expectUp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'd10, 1'b1, 1'b1},   // R7 inside window
    '{8'd70, 1'b1, 1'b1},   // R7 at MAX_GAP
    '{8'd71, 1'b1, 1'b0},   // R7 just past window
    '{8'd4,  1'b1, 1'b1},   // R8 exactly MIN_GAP accepted
    '{8'd3,  1'b1, 1'b0},   // R8 too soon: noise
    '{8'd20, 1'b0, 1'b0},   // R9 reversed polarity
    '{8'd1,  1'b1, 1'b0}    // R8 very early
  };

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runTicks(input int n);
    repeat (n) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
      repeat (TICK_CYC - 2) @(negedge clk);
    end
  endtask

  task automatic sendPulse(input logic pol);
    @(negedge clk) begin pulseSeen = 1'b1; pulsePolOk = pol; end
    @(negedge clk) begin pulseSeen = 1'b0; pulsePolOk = 1'b1; end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    txActive = 1'b0; rxFrame = 1'b0; msTick = 1'b0; pulseSeen = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic bringUp();
    doReset();
    @(negedge clk) rxFrame = 1'b1;
    @(negedge clk) rxFrame = 1'b0;
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rc;
    // R1 reset state
    doReset();
    check(int'(linkFail), 1, "R1 linkFail after reset");
    check(int'({txEnable, rxEnable, loopEnable}), 0, "R1 enables after reset");
    check(int'(linkPulse), 0, "R1 linkPulse after reset");

    // R5 pulses continue in link fail while transmitting
    @(negedge clk) txActive = 1'b1;
    rc = riseCount;
    runTicks(40);
    check(int'(riseCount - rc >= 2), 1, "R5 pulses in fail while txActive");
    check(int'({txEnable, rxEnable, loopEnable}), 0, "R5 enables held off");
    txActive = 1'b0;

    // R7/R8/R9 vector table
    foreach (VECS[i]) begin
      doReset();
      sendPulse(1'b1);
      runTicks(int'(VECS[i].gap));
      sendPulse(VECS[i].polOk);
      idle(2);
      check(int'(!linkFail), int'(VECS[i].expectUp), "R7 pulse pair vector");
    end

    // R8 noise does not restart the spacing window
    doReset();
    sendPulse(1'b1);
    runTicks(2);
    sendPulse(1'b1);
    runTicks(2);
    sendPulse(1'b1);
    idle(2);
    check(int'(linkFail), 0, "R8 noise ignored, window from first pulse");

    // R6 frame qualifies, waits for idle
    doReset();
    @(negedge clk) begin txActive = 1'b1; rxFrame = 1'b1; end
    idle(2);
    check(int'(linkFail), 1, "R6 armed while both active");
    rxFrame = 1'b0;
    idle(2);
    check(int'(linkFail), 1, "R6 armed while txActive");
    txActive = 1'b0;
    idle(2);
    check(int'(linkFail), 0, "R6 up after idle");
    check(int'({txEnable, rxEnable, loopEnable}), 7, "R6 enables restored");

    // R2 pulse cadence and width
    runTicks(50);
    check(lastPeriod, TX_PERIOD * TICK_CYC, "R2 pulse period in cycles");
    check(lastWidth, STROBE_CYC, "R2 pulse width in cycles");

    // R3 silence during and after transmit
    @(negedge clk) txActive = 1'b1;
    idle(STROBE_CYC + 2);
    rc = riseCount;
    runTicks(20);
    check(riseCount, rc, "R3 no pulse while transmitting");
    @(negedge clk) txActive = 1'b0;
    rc = riseCount;
    runTicks(TX_PERIOD - 1);
    check(riseCount, rc, "R3 silent interval first");
    runTicks(1);
    check(riseCount, rc + 1, "R3 first pulse after TX_PERIOD ticks");

    // R4 loss time
    bringUp();
    runTicks(LOSS_TIME - 1);
    check(int'(linkFail), 0, "R4 up one tick before loss");
    runTicks(1);
    check(int'(linkFail), 1, "R4 fail at loss time");

    // R4 accepted pulse restarts loss count
    bringUp();
    runTicks(90);
    sendPulse(1'b1);
    runTicks(90);
    check(int'(linkFail), 0, "R4 good pulse restarts loss");

    // R9 reversed pulse does not restart loss count
    bringUp();
    runTicks(90);
    sendPulse(1'b0);
    runTicks(5);
    check(int'(linkFail), 1, "R9 reversed pulse ignored by loss");

    // R10 disabled
    doReset();
    @(negedge clk) testEnable = 1'b0;
    #1;
    check(int'(linkFail), 0, "R10 linkFail low when disabled");
    check(int'({txEnable, rxEnable, loopEnable}), 7, "R10 enables when disabled");
    rc = riseCount;
    runTicks(120);
    check(riseCount, rc, "R10 no pulses when disabled");
    check(int'(linkFail), 0, "R10 no fail after long silence");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule